// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two unsigned operands and a carry-in. The operand width is cut into blocks that grow wider toward the most significant end. The lowest block is a plain ripple adder fed by the external carry-in. Each higher block forms its propagate and generate terms once. It then runs two ripple carry chains over them in parallel, one that assumes an incoming carry of 0 and one that assumes 1. When the true carry reaches the block, a multiplexer keeps the matching sum and carry-out. That carry-out then becomes the select for the next block.

The select carry passes through one multiplexer per block. Each block is one bit wider than the block below it, so its two candidate results are ready about when its select arrives. The partition is an integer array parameter, so other splits are possible. The default is 20 bits in blocks of 2, 3, 4, 5 and 6 bits, which start at bits 0, 2, 5, 9 and 14. The sum and carry-out are captured in output registers with a synchronous active-high reset, so a result appears one clock after its operands are presented.

Top module: `csel_sqrt_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_o` and `cout_o` are cleared to 0 at that edge, whatever the operand inputs are.
- R2: The result of operands presented before a rising edge appears on the outputs just after that edge, and the outputs hold that value until the next edge.
- R3: `{cout_o, sum_o}` equals `a_i + b_i + cin_i` computed over WIDTH+1 bits. `sum_o` is the low WIDTH bits and `cout_o` is bit WIDTH.
- R4: The lowest block adds directly from `cin_i`. A carry produced within it (for example, bits 0 and 1 all ones plus `cin_i` = 1) enters bit 2.
- R5: With `a_i` all ones, `b_i` zero and `cin_i` = 1, the carry travels through every block, giving `sum_o` = 0 and `cout_o` = 1.
- R6: A carry generated at the top bit of any block, with all higher bits propagating, selects the carry-in-1 result in every block above it and reaches `cout_o`.
- R7: With `a_i` all ones, `b_i` zero and `cin_i` = 0, every block selects its carry-in-0 result: `sum_o` is all ones and `cout_o` = 0.
- R8: `cout_o` is the selected carry-out of the most significant block. Setting only the top bit of both operands gives `cout_o` = 1 and `sum_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry out of the top bit |

## Verification
The bench builds the block with its default parameters: 20 bits split into blocks of 2, 3, 4, 5 and 6 bits. With that split there are four block boundaries, at bits 2, 5, 9 and 14, so a carry can be launched from the top bit of each block and driven through every multiplexer above it. Every selection path can therefore be reached with both candidate results. The all-ones operand cases with both carry-in values exercise the carry-in-0 and carry-in-1 halves of every block together.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int CSEL_DEF_WIDTH = 20;
  localparam int CSEL_DEF_NBLK  = 5;
  localparam int CSEL_DEF_PART [CSEL_DEF_NBLK] = '{2, 3, 4, 5, 6};
endpackage

// File: rtl/csel_pg.sv
module csel_pg #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o,
  output logic [W-1:0] g_o
);
  assign p_o = a_i ^ b_i;
  assign g_o = a_i & b_i;
endmodule

// File: rtl/csel_chain.sv
module csel_chain #(
  parameter int W = 4
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] g_i,
  input  logic         ci_i,
  output logic [W:0]   c_o
);
  assign c_o[0] = ci_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign c_o[i+1] = g_i[i] | (p_i[i] & c_o[i]);
  end
endmodule

// File: rtl/csel_sel_blk.sv
// One select block: shared propagate/generate, two speculative chains, output mux.
module csel_sel_blk #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W-1:0] p, g;
  logic [W:0]   c_zero, c_one;

  csel_pg #(.W(W)) pg_i (.a_i(a_i), .b_i(b_i), .p_o(p), .g_o(g));
  csel_chain #(.W(W)) chain0_i (.p_i(p), .g_i(g), .ci_i(1'b0), .c_o(c_zero));
  csel_chain #(.W(W)) chain1_i (.p_i(p), .g_i(g), .ci_i(1'b1), .c_o(c_one));

  assign s_o  = sel_i ? (p ^ c_one[W-1:0]) : (p ^ c_zero[W-1:0]);
  assign co_o = sel_i ? c_one[W] : c_zero[W];
endmodule

// File: rtl/csel_sqrt_adder.sv
module csel_sqrt_adder
  import csel_pkg::*;
#(
  parameter int WIDTH = CSEL_DEF_WIDTH,
  parameter int NBLK  = CSEL_DEF_NBLK,
  parameter int PART [NBLK] = CSEL_DEF_PART
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  function automatic int blk_lo(input int k);
    int s;
    s = 0;
    for (int j = 0; j < k; j++) s += PART[j];
    return s;
  endfunction

  logic [NBLK:0]    cy;
  logic [WIDTH-1:0] sum_c;

  assign cy[0] = cin_i;

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    localparam int LO = blk_lo(k);
    localparam int BW = PART[k];
    if (k == 0) begin : g_ripple
      logic [BW-1:0] p, g;
      logic [BW:0]   c;
      csel_pg #(.W(BW)) pg_i (.a_i(a_i[LO +: BW]), .b_i(b_i[LO +: BW]),
                              .p_o(p), .g_o(g));
      csel_chain #(.W(BW)) chain_i (.p_i(p), .g_i(g), .ci_i(cy[k]), .c_o(c));
      assign sum_c[LO +: BW] = p ^ c[BW-1:0];
      assign cy[k+1]         = c[BW];
    end else begin : g_select
      csel_sel_blk #(.W(BW)) sel_i (
        .a_i  (a_i[LO +: BW]),
        .b_i  (b_i[LO +: BW]),
        .sel_i(cy[k]),
        .s_o  (sum_c[LO +: BW]),
        .co_o (cy[k+1])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_c;
      cout_o <= cy[NBLK];
    end
  end
endmodule

// File: rtl/csel_sqrt_adder_chk.sv
module csel_sqrt_adder_chk #(
  parameter int WIDTH = 20
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);
  localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (sum_o == '0 && !cout_o));

  assert_sum_match_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      ({cout_o, sum_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + $past(cin_i))));

  assert_full_chain_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_i) == ALL1 && $past(b_i) == '0 && $past(cin_i))
      |-> (sum_o == '0 && cout_o));

  assert_zero_select_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_i) == ALL1 && $past(b_i) == '0 && !$past(cin_i))
      |-> (sum_o == ALL1 && !cout_o));
endmodule

bind csel_sqrt_adder csel_sqrt_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
  .sum_o(sum_o), .cout_o(cout_o)
);

// File: tb/csel_sqrt_adder_tb_top.sv
`timescale 1ns/1ps
module csel_sqrt_adder_tb_top;
  localparam int W  = 20;
  localparam int NB = 5;
  localparam int BW [NB] = '{2, 3, 4, 5, 6};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic cin = 1'b0;
  logic [W-1:0] sum;
  logic cout;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csel_sqrt_adder dut_i (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout)
  );

  task automatic cmp(input logic [W:0] got, input logic [W:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic add_check(input logic [W-1:0] x, input logic [W-1:0] y,
                           input logic c, input string req);
    logic [W:0] exp;
    @(negedge clk);
    a = x; b = y; cin = c;
    exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    @(posedge clk);
    #1;
    cmp({cout, sum}, exp, req);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; a = '1; b = '1; cin = 1'b1;
    @(posedge clk); #1;
    cmp({cout, sum}, '0, "R1 reset clears");
    @(negedge clk);
    a = 20'h12345; b = 20'h0F0F0;
    @(posedge clk); #1;
    cmp({cout, sum}, '0, "R1 reset holds with inputs");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    add_check(20'h00100, 20'h00023, 1'b0, "R2 first result");
    @(negedge clk);
    a = 20'hABCDE; b = 20'h11111; cin = 1'b1;
    #1;
    cmp({cout, sum}, 21'h00123, "R2 hold before edge");
    @(posedge clk); #1;
    cmp({cout, sum}, 21'h0BCDF0, "R2 new result after edge");
  endtask

  task automatic t_lowest;
    add_check(20'h00003, 20'h00000, 1'b1, "R4 carry out of block 0");
    add_check(20'h00001, 20'h00001, 1'b0, "R4 generate in block 0");
    add_check(20'h00000, 20'h00000, 1'b1, "R4 carry-in only");
  endtask

  task automatic t_full_chain;
    add_check('1, '0, 1'b1, "R5 carry through all blocks");
    add_check('0, '1, 1'b1, "R5 carry through all blocks swapped");
    add_check('1, '0, 1'b0, "R7 carry-in 0 all ones");
    add_check('1, '1, 1'b0, "R7 all ones plus all ones");
  endtask

  task automatic t_boundaries;
    int lo;
    lo = 0;
    for (int k = 0; k < NB - 1; k++) begin
      logic [W-1:0] x, y;
      lo += BW[k];
      y = '0;
      y[lo-1] = 1'b1;
      x = '1 << (lo - 1);
      add_check(x, y, 1'b0, "R6 generate at block top");
      add_check(x, y, 1'b1, "R6 generate at block top with cin");
    end
  endtask

  task automatic t_top_cout;
    add_check(20'h80000, 20'h80000, 1'b0, "R8 top block carry-out");
    add_check(20'h7FFFF, 20'h00000, 1'b1, "R8 carry into top bit only");
  endtask

  task automatic t_sweep;
    logic [31:0] lf;
    lf = 32'hACE1_2345;
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] x, y;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      x = lf[W-1:0];
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      y = lf[W+2:3];
      add_check(x, y, lf[7], "R3 mixed operands");
    end
    add_check(20'h55555, 20'hAAAAA, 1'b1, "R3 alternating");
    add_check(20'h0000F, 20'hFFFF1, 1'b0, "R3 wrap");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_lowest();
    t_full_chain();
    t_boundaries();
    t_top_cout();
    t_sweep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule